// File: doc/BRIEF.md
# NAND Status and Busy Tracker

This block keeps the ready/busy state of a NAND flash device model and builds the 8-bit status byte that a status-read command returns. It receives start pulses for a page load, a page program and a block erase. It also receives a completion pulse with a pass/fail flag from the program/erase engine and byte-wise verify samples taken during programming. The write-protect input and decoded command strobes complete the input set.

It decides whether each incoming command is accepted or rejected. While an internal operation runs, only status-read and reset get through. A reset aborts a running operation, requests that the address and data registers be cleared, and holds busy for a bounded number of cycles. That count differs for a reset from ready and a reset from busy. A reset that arrives during a reset is refused.

The busy output is an active-high pull-down enable for an open-drain ready/busy pin. A status-output mode flag tells the data-out path to return the status byte on every read cycle.

Top module: `nst_status_tracker`

## Requirements
- R1: The status byte is {wp_n as sampled one cycle earlier, 1 when ready / 0 when busy, 5'b00000, fail bit}; after power-on reset with wp_n high and no activity it reads C0h.
- R2: Command codes on cmd_op are 0 read, 1 read-id, 2 program setup, 3 program confirm, 4 erase setup, 5 erase confirm, 6 status read, 7 reset. While a page load, program or erase is busy, only codes 6 and 7 are accepted. A strobe is answered by a one-cycle cmd_accept or cmd_reject pulse in the cycle after it.
- R3: While ready, every code is accepted, except that codes 2 to 5 are rejected when the sampled write-protect is low.
- R4: A start pulse seen while ready makes rb_oe high from the next cycle until eng_done. If several arrive together, program wins over erase, and erase wins over load. Start pulses seen while busy are ignored.
- R5: With the sampled write-protect low, program and erase start pulses are ignored and the block stays ready.
- R6: When a program completes, bit 0 becomes eng_fail OR a verify miss. A miss is any verify sample taken during that program, including the completing cycle, that has a bit with target 0 and read-back 1. When an erase completes, bit 0 becomes eng_fail. Bit 0 holds until the next completion or reset.
- R7: An accepted reset during a load, program or erase pulses eng_abort and regs_clear once, holds rb_oe high for exactly RST_BUSY_CYC cycles, and clears bit 0, so the status then reads C0h with wp_n high.
- R8: An accepted reset while ready pulses regs_clear without eng_abort and holds rb_oe high for exactly RST_IDLE_CYC cycles.
- R9: During a reset busy period, only status read is accepted. A second reset is rejected and neither restarts the count nor pulses regs_clear.
- R10: chip-enable high (ce_n=1) during a page load returns the block to ready in the next cycle. During a program or erase it is ignored.
- R11: stat_mode rises after an accepted status read and stays high until another command is accepted.
- R12: eng_done and eng_fail seen while ready leave the status byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_n | input | 1 | Write-protect, low blocks program and erase |
| ce_n | input | 1 | Chip enable, active low |
| cmd_stb | input | 1 | Decoded command strobe |
| cmd_op | input | 3 | Decoded command code (see R2) |
| ld_start | input | 1 | Page-load start pulse (read address complete) |
| pg_start | input | 1 | Program start pulse (confirm) |
| er_start | input | 1 | Erase start pulse (confirm) |
| eng_done | input | 1 | Engine completion pulse |
| eng_fail | input | 1 | Engine failure flag, valid with eng_done |
| vfy_stb | input | 1 | Verify sample strobe |
| vfy_tgt | input | VFY_W | Byte intended to be programmed |
| vfy_rd | input | VFY_W | Byte read back from the cells |
| rb_oe | output | 1 | Pull-down enable for the ready/busy pin (1 = busy) |
| status | output | 8 | Status byte |
| cmd_accept | output | 1 | Command accepted pulse |
| cmd_reject | output | 1 | Command rejected pulse |
| stat_mode | output | 1 | Status-output mode active |
| eng_abort | output | 1 | Abort request to the engine |
| regs_clear | output | 1 | Clear address registers to zero and data registers to ones |

## Verification
On every cycle the assertions check the busy-time command gating, the refusal of a reset during a reset, the write-protect block on starts, and that chip enable cannot end a program or erase. They also check that every clear pulse comes with busy and a cleared fail bit, and that a status read always enters status mode. The exact length of each reset busy period, the pass/fail value for every verify pattern, and the full acceptance table across states, codes and write-protect can only be shown by the bench's scenarios. The same holds for a done pulse having no effect while ready.

// File: rtl/nst_pkg.sv
package nst_pkg;
  typedef enum logic [2:0] {
    OP_READ        = 3'd0,
    OP_READ_ID     = 3'd1,
    OP_PROG_SETUP  = 3'd2,
    OP_PROG_GO     = 3'd3,
    OP_ERASE_SETUP = 3'd4,
    OP_ERASE_GO    = 3'd5,
    OP_STATUS      = 3'd6,
    OP_RESET       = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    ST_READY = 3'd0,
    ST_LOAD  = 3'd1,
    ST_PROG  = 3'd2,
    ST_ERASE = 3'd3,
    ST_RST   = 3'd4
  } st_e;
endpackage

// File: rtl/nst_cmd_gate.sv
module nst_cmd_gate
  import nst_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic stb,
  input  op_e  op,
  input  st_e  st,
  input  logic wp_ok,
  output logic ok,
  output logic acc_q,
  output logic rej_q
);
  always_comb begin
    ok = 1'b0;
    if (stb) begin
      case (st)
        ST_READY: begin
          case (op)
            OP_PROG_SETUP, OP_PROG_GO, OP_ERASE_SETUP, OP_ERASE_GO: ok = wp_ok;
            default: ok = 1'b1;
          endcase
        end
        ST_LOAD, ST_PROG, ST_ERASE: ok = (op == OP_STATUS) || (op == OP_RESET);
        ST_RST:  ok = (op == OP_STATUS);
        default: ok = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= 1'b0;
      rej_q <= 1'b0;
    end else begin
      acc_q <= ok;
      rej_q <= stb && !ok;
    end
  end
endmodule

// File: rtl/nst_verify.sv
module nst_verify #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         active,
  input  logic         stb,
  input  logic [W-1:0] tgt,
  input  logic [W-1:0] rd,
  output logic         miss
);
  logic         acc_q;
  logic [W-1:0] stuck;
  logic         now_bad;

  // a bit meant to go from 1 to 0 that still reads 1
  assign stuck   = ~tgt & rd;
  assign now_bad = stb && active && (|stuck);
  assign miss    = acc_q || now_bad;

  always_ff @(posedge clk) begin
    if (rst || !active) acc_q <= 1'b0;
    else if (now_bad)   acc_q <= 1'b1;
  end
endmodule

// File: rtl/nst_busy_fsm.sv
module nst_busy_fsm
  import nst_pkg::*;
#(
  parameter int RST_IDLE_CYC = 500,
  parameter int RST_BUSY_CYC = 1000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wp_n,
  input  logic       ce_n,
  input  logic       rst_go,
  input  logic       ld_start,
  input  logic       pg_start,
  input  logic       er_start,
  input  logic       eng_done,
  input  logic       eng_fail,
  input  logic       vfy_miss,
  output st_e        st,
  output logic       wp_q,
  output logic [7:0] status,
  output logic       abort_q,
  output logic       clear_q
);
  localparam int MAXC = (RST_IDLE_CYC > RST_BUSY_CYC) ? RST_IDLE_CYC : RST_BUSY_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] IDLE_LD = CW'(RST_IDLE_CYC - 1);
  localparam logic [CW-1:0] BUSY_LD = CW'(RST_BUSY_CYC - 1);

  st_e         st_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic        fail_q, fail_n;
  logic        abort_n, clear_n;

  always_comb begin
    st_n    = st;
    cnt_n   = cnt_q;
    fail_n  = fail_q;
    abort_n = 1'b0;
    clear_n = 1'b0;
    if (rst_go) begin
      clear_n = 1'b1;
      abort_n = (st != ST_READY);
      fail_n  = 1'b0;
      st_n    = ST_RST;
      cnt_n   = (st == ST_READY) ? IDLE_LD : BUSY_LD;
    end else begin
      case (st)
        ST_READY: begin
          if (pg_start && wp_q)      st_n = ST_PROG;
          else if (er_start && wp_q) st_n = ST_ERASE;
          else if (ld_start)         st_n = ST_LOAD;
        end
        ST_LOAD: if (ce_n || eng_done) st_n = ST_READY;
        ST_PROG: if (eng_done) begin
          fail_n = eng_fail || vfy_miss;
          st_n   = ST_READY;
        end
        ST_ERASE: if (eng_done) begin
          fail_n = eng_fail;
          st_n   = ST_READY;
        end
        ST_RST: begin
          if (cnt_q == '0) st_n = ST_READY;
          else             cnt_n = cnt_q - 1'b1;
        end
        default: st_n = ST_READY;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_READY;
      cnt_q   <= '0;
      fail_q  <= 1'b0;
      wp_q    <= 1'b0;
      abort_q <= 1'b0;
      clear_q <= 1'b0;
    end else begin
      st      <= st_n;
      cnt_q   <= cnt_n;
      fail_q  <= fail_n;
      wp_q    <= wp_n;
      abort_q <= abort_n;
      clear_q <= clear_n;
    end
  end

  assign status = {wp_q, (st == ST_READY), 5'b00000, fail_q};
endmodule

// File: rtl/nst_status_tracker.sv
module nst_status_tracker
  import nst_pkg::*;
#(
  parameter int RST_IDLE_CYC = 500,
  parameter int RST_BUSY_CYC = 1000,
  parameter int VFY_W        = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wp_n,
  input  logic             ce_n,
  input  logic             cmd_stb,
  input  logic [2:0]       cmd_op,
  input  logic             ld_start,
  input  logic             pg_start,
  input  logic             er_start,
  input  logic             eng_done,
  input  logic             eng_fail,
  input  logic             vfy_stb,
  input  logic [VFY_W-1:0] vfy_tgt,
  input  logic [VFY_W-1:0] vfy_rd,
  output logic             rb_oe,
  output logic [7:0]       status,
  output logic             cmd_accept,
  output logic             cmd_reject,
  output logic             stat_mode,
  output logic             eng_abort,
  output logic             regs_clear
);
  op_e  op;
  st_e  st;
  logic wp_q;
  logic cmd_ok;
  logic rst_go;
  logic vfy_miss;

  assign op     = op_e'(cmd_op);
  assign rst_go = cmd_ok && (op == OP_RESET);

  nst_cmd_gate u_gate (
    .clk   (clk),
    .rst   (rst),
    .stb   (cmd_stb),
    .op    (op),
    .st    (st),
    .wp_ok (wp_q),
    .ok    (cmd_ok),
    .acc_q (cmd_accept),
    .rej_q (cmd_reject)
  );

  nst_verify #(.W(VFY_W)) u_vfy (
    .clk    (clk),
    .rst    (rst),
    .active (st == ST_PROG),
    .stb    (vfy_stb),
    .tgt    (vfy_tgt),
    .rd     (vfy_rd),
    .miss   (vfy_miss)
  );

  nst_busy_fsm #(
    .RST_IDLE_CYC (RST_IDLE_CYC),
    .RST_BUSY_CYC (RST_BUSY_CYC)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .wp_n     (wp_n),
    .ce_n     (ce_n),
    .rst_go   (rst_go),
    .ld_start (ld_start),
    .pg_start (pg_start),
    .er_start (er_start),
    .eng_done (eng_done),
    .eng_fail (eng_fail),
    .vfy_miss (vfy_miss),
    .st       (st),
    .wp_q     (wp_q),
    .status   (status),
    .abort_q  (eng_abort),
    .clear_q  (regs_clear)
  );

  assign rb_oe = (st != ST_READY);

  always_ff @(posedge clk) begin
    if (rst)         stat_mode <= 1'b0;
    else if (cmd_ok) stat_mode <= (op == OP_STATUS);
  end
endmodule

// File: rtl/nst_status_tracker_chk.sv
module nst_status_tracker_chk
  import nst_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input st_e        st,
  input logic       cmd_stb,
  input logic [2:0] cmd_op,
  input logic       ce_n,
  input logic       eng_done,
  input logic       ld_start,
  input logic       pg_start,
  input logic       er_start,
  input logic       rb_oe,
  input logic [7:0] status,
  input logic       cmd_reject,
  input logic       stat_mode,
  input logic       eng_abort,
  input logic       regs_clear
);
  // R2
  busy_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_LOAD || st == ST_PROG || st == ST_ERASE) && cmd_stb &&
     cmd_op != 3'd6 && cmd_op != 3'd7) |=> cmd_reject);

  // R5
  wp_block_chk: assert property (@(posedge clk) disable iff (rst)
    (!rb_oe && !status[7] && (pg_start || er_start) && !ld_start && !cmd_stb) |=> !rb_oe);

  // R7
  clear_busy_chk: assert property (@(posedge clk) disable iff (rst)
    regs_clear |-> (rb_oe && !status[6] && !status[0]));

  // R7
  abort_clear_chk: assert property (@(posedge clk) disable iff (rst)
    eng_abort |-> regs_clear);

  // R9
  rst_twice_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RST && cmd_stb && cmd_op == 3'd7) |=> (cmd_reject && !regs_clear && !eng_abort));

  // R10
  ce_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_PROG || st == ST_ERASE) && ce_n && !eng_done &&
     !(cmd_stb && cmd_op == 3'd7)) |=> rb_oe);

  // R11
  smode_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_stb && cmd_op == 3'd6) |=> stat_mode);
endmodule

bind nst_status_tracker nst_status_tracker_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .st         (st),
  .cmd_stb    (cmd_stb),
  .cmd_op     (cmd_op),
  .ce_n       (ce_n),
  .eng_done   (eng_done),
  .ld_start   (ld_start),
  .pg_start   (pg_start),
  .er_start   (er_start),
  .rb_oe      (rb_oe),
  .status     (status),
  .cmd_reject (cmd_reject),
  .stat_mode  (stat_mode),
  .eng_abort  (eng_abort),
  .regs_clear (regs_clear)
);

// File: tb/test_nst_status_tracker.sv
module test_nst_status_tracker;
  localparam int CLK_PER = 10;
  localparam int IDLE_N  = 4;
  localparam int BUSY_N  = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wp_n = 1'b1, ce_n = 1'b0;
  logic       cmd_stb = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic       ld_start = 1'b0, pg_start = 1'b0, er_start = 1'b0;
  logic       eng_done = 1'b0, eng_fail = 1'b0;
  logic       vfy_stb = 1'b0;
  logic [7:0] vfy_tgt = 8'h00, vfy_rd = 8'h00;
  logic       rb_oe, cmd_accept, cmd_reject, stat_mode, eng_abort, regs_clear;
  logic [7:0] status;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PER/2) clk = ~clk;

  nst_status_tracker #(.RST_IDLE_CYC(IDLE_N), .RST_BUSY_CYC(BUSY_N), .VFY_W(8)) i_nst_status_tracker (
    .clk(clk), .rst(rst), .wp_n(wp_n), .ce_n(ce_n), .cmd_stb(cmd_stb), .cmd_op(cmd_op),
    .ld_start(ld_start), .pg_start(pg_start), .er_start(er_start),
    .eng_done(eng_done), .eng_fail(eng_fail), .vfy_stb(vfy_stb), .vfy_tgt(vfy_tgt), .vfy_rd(vfy_rd),
    .rb_oe(rb_oe), .status(status), .cmd_accept(cmd_accept), .cmd_reject(cmd_reject),
    .stat_mode(stat_mode), .eng_abort(eng_abort), .regs_clear(regs_clear));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic quiet();
    cmd_stb = 0; ld_start = 0; pg_start = 0; er_start = 0;
    eng_done = 0; eng_fail = 0; vfy_stb = 0;
  endtask

  task automatic settle();
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); quiet(); eng_done = rb_oe;
    end
    @(negedge clk); quiet(); wp_n = 1; ce_n = 0;
    @(negedge clk);
  endtask

  function automatic int exp_ok(int s, int op, int w);
    if (s == 0) return (op >= 2 && op <= 5) ? w : 1;
    if (s == 4) return (op == 6) ? 1 : 0;
    return (op == 6 || op == 7) ? 1 : 0;
  endfunction

  // counts samples with rb_oe high, starting at the current sample
  task automatic count_busy(output int n);
    n = 0;
    while (rb_oe && n < 100) begin n++; @(negedge clk); quiet(); end
  endtask

  initial begin
    #(CLK_PER * 100000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    int n;
    int fexp;
    repeat (3) @(negedge clk);
    rst = 0;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 status after reset", status, 8'hC0);
    chk("R1 rb_oe after reset", rb_oe, 0);

    // R2 R3 R9: acceptance across states, codes and write-protect
    for (int s = 0; s < 5; s++)
      for (int op = 0; op < 8; op++)
        for (int w = 0; w < 2; w++) begin
          @(negedge clk);
          case (s)
            1: ld_start = 1;
            2: pg_start = 1;
            3: er_start = 1;
            4: begin cmd_stb = 1; cmd_op = 3'd7; end
            default: ;
          endcase
          @(negedge clk); quiet(); wp_n = w[0];
          @(negedge clk); cmd_stb = 1; cmd_op = op[2:0];
          @(negedge clk); quiet();
          chk($sformatf("R2/R3/R9 accept s=%0d op=%0d wp=%0d", s, op, w), cmd_accept, exp_ok(s, op, w));
          chk($sformatf("R2 reject s=%0d op=%0d wp=%0d", s, op, w), cmd_reject, 1 - exp_ok(s, op, w));
          settle();
        end

    // R4 busy through a load until done; start ignored while busy
    @(negedge clk); ld_start = 1;
    @(negedge clk); quiet(); pg_start = 1;
    @(negedge clk); quiet();
    chk("R4 load busy", rb_oe, 1);
    eng_done = 1;
    @(negedge clk); quiet();
    chk("R4 ready after done (program start ignored)", rb_oe, 0);
    // R4 priority: program over erase and load
    @(negedge clk); pg_start = 1; er_start = 1; ld_start = 1;
    @(negedge clk); quiet(); eng_done = 1; eng_fail = 1;
    @(negedge clk); quiet();
    chk("R4 priority program sets fail", status, 8'hC1);

    // R12 done while ready ignored
    @(negedge clk); eng_done = 1; eng_fail = 0;
    @(negedge clk); quiet();
    chk("R12 done while ready", status, 8'hC1);

    // R6 verify sweep
    for (int t = 0; t < 16; t++)
      for (int r = 0; r < 16; r++) begin
        @(negedge clk); pg_start = 1;
        @(negedge clk); quiet();
        vfy_stb = 1; vfy_tgt = {t[3:0], ~t[3:0]}; vfy_rd = {r[3:0], r[3:0]};
        fexp = ((~{t[3:0], ~t[3:0]} & {r[3:0], r[3:0]}) != 0) ? 1 : 0;
        @(negedge clk); quiet(); eng_done = 1;
        @(negedge clk); quiet();
        chk($sformatf("R6 verify t=%0h r=%0h", t, r), status, 8'hC0 | fexp);
      end
    // R6 miss on the completing cycle
    @(negedge clk); pg_start = 1;
    @(negedge clk); quiet(); eng_done = 1; vfy_stb = 1; vfy_tgt = 8'hFE; vfy_rd = 8'h01;
    @(negedge clk); quiet();
    chk("R6 miss in done cycle", status, 8'hC1);
    // R6 erase pass then fail, busy bit clear during erase
    @(negedge clk); er_start = 1;
    @(negedge clk); quiet();
    chk("R1 busy status during erase", status, 8'h81);
    eng_done = 1;
    @(negedge clk); quiet();
    chk("R6 erase pass", status, 8'hC0);
    @(negedge clk); er_start = 1;
    @(negedge clk); quiet(); eng_done = 1; eng_fail = 1;
    @(negedge clk); quiet();
    chk("R6 erase fail", status, 8'hC1);

    // R5 write-protect low blocks program and erase
    @(negedge clk); wp_n = 0;
    @(negedge clk); pg_start = 1;
    @(negedge clk); quiet(); er_start = 1;
    @(negedge clk); quiet();
    chk("R5 protected stays ready", rb_oe, 0);
    chk("R1 protected status", status, 8'h41);
    wp_n = 1;
    @(negedge clk);

    // R10 chip enable
    @(negedge clk); ld_start = 1;
    @(negedge clk); quiet(); ce_n = 1;
    @(negedge clk); quiet(); ce_n = 0;
    chk("R10 load aborted by ce_n", rb_oe, 0);
    @(negedge clk); pg_start = 1;
    @(negedge clk); quiet(); ce_n = 1;
    @(negedge clk); quiet();
    @(negedge clk);
    chk("R10 program ignores ce_n", rb_oe, 1);
    ce_n = 0;
    settle();

    // R7 reset from busy
    @(negedge clk); pg_start = 1;
    @(negedge clk); quiet(); cmd_stb = 1; cmd_op = 3'd7;
    @(negedge clk); quiet();
    chk("R7 abort pulse", eng_abort, 1);
    chk("R7 clear pulse", regs_clear, 1);
    count_busy(n);
    chk("R7 busy length", n, BUSY_N);
    chk("R7 status after reset", status, 8'hC0);

    // R8 reset from ready
    @(negedge clk); cmd_stb = 1; cmd_op = 3'd7;
    @(negedge clk); quiet();
    chk("R8 no abort from ready", eng_abort, 0);
    chk("R8 clear pulse", regs_clear, 1);
    count_busy(n);
    chk("R8 busy length", n, IDLE_N);

    // R9 reset during reset
    @(negedge clk); cmd_stb = 1; cmd_op = 3'd7;
    @(negedge clk); cmd_stb = 1; cmd_op = 3'd7;
    @(negedge clk); quiet();
    chk("R9 second reset rejected", cmd_reject, 1);
    chk("R9 no second clear", regs_clear, 0);
    count_busy(n);
    chk("R9 busy not restarted", n + 1, IDLE_N);

    // R11 status mode
    @(negedge clk); cmd_stb = 1; cmd_op = 3'd6;
    @(negedge clk); quiet();
    repeat (3) @(negedge clk);
    chk("R11 status mode held", stat_mode, 1);
    cmd_stb = 1; cmd_op = 3'd0;
    @(negedge clk); quiet();
    chk("R11 status mode left", stat_mode, 0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule